// File: doc/BRIEF.md
# Random Word Generator Register Block

This block is a memory-mapped random word source behind a 32-bit register bus with three registers: control, status and data. A 32-bit LFSR stands in for a noise source. Its words pass through a short conditioning pipeline into a four-word output FIFO. The status register reports when the FIFO holds a full burst of four words. The data register returns the word at the FIFO head and pops it.

The block reports two error classes, seed faults and clock faults. Each error has a live bit and a sticky flag, and software clears a sticky flag by writing 0 to it. A seed fault stops all output and empties the FIFO and the pipeline. After software clears the sticky seed flag, it must perform a fixed number of discarding data reads. Fresh generation only restarts once those reads are done. Two test inputs let a bench force a seed fault and a clock fault.

A bus access takes one cycle. A write commits at the clock edge. Read data is combinational from the current state, and a data read pops at the same edge.

Top module: `rng_regif`

## Requirements
- R1: After reset the control register (offset 0x0) and the status register (offset 0x4) both read 0, `irq` is low, and a data read (offset 0x8) returns 0.
- R2: The control register keeps bit 2 (generation enable), bit 3 (interrupt enable) and bit 5 (clock-error masking, 1 = masked). All other bits read 0.
- R3: Status bit 0 (ready) is 1 exactly when generation is enabled, no seed error is live or flagged, no drain is pending, and the FIFO holds four words. Ready rises within 30 cycles of enabling, and four back-to-back data reads then return four distinct words. A data read while ready is low and no drain is pending returns 0 and pops nothing.
- R4: While enabled, an asserted `fault_inject` sets status bit 2 (live seed error) and bit 6 (sticky seed flag) at the next edge. Ready falls and data reads return 0.
- R5: Writing 0 to status bit 6 clears the sticky seed flag. Writing 1 to it leaves it unchanged. Bit 2 follows `fault_inject` and cannot be written.
- R6: Clearing the sticky seed flag starts a drain of 12 data reads. Ready stays low until all 12 reads are done, whatever the wait. Ready rises within 30 cycles after the 12th read.
- R7: Writing control with bit 2 clear empties the FIFO and the pipeline, so ready reads 0 in the next cycle. Re-enabling refills from empty: ready is 0 one cycle after re-enabling and rises later.
- R8: With the clock-error mask bit clear, an asserted `clk_fault` sets status bit 1 (live) and bit 5 (sticky). Bit 5 is cleared by writing 0 to it. Ready is unaffected. With the mask bit set, `clk_fault` has no effect.
- R9: `irq` is high when interrupt enable is set and any of ready, the sticky seed flag or the sticky clock flag is set. It is low when interrupt enable is clear.
- R10: A write of 0 to bit 6 while the seed fault is still present leaves the flag set and starts no drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| fault_inject | input | 1 | Forces a seed fault of the noise stand-in |
| clk_fault | input | 1 | Forces a clock fault indication |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is the drain window. It only opens after a sticky seed flag has been set and then cleared while the fault is already gone. The bench forces the fault with `fault_inject` and first tries to clear the flag while the fault is still asserted, which must open no window. It then releases the fault, clears the flag, and makes 11 discarding reads. After a long idle wait it checks that ready is still low, then makes the 12th read and waits for ready to return.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam logic [3:0]  OFF_CTRL = 4'h0;
  localparam logic [3:0]  OFF_STAT = 4'h4;
  localparam logic [3:0]  OFF_DATA = 4'h8;
  // control bit positions
  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_IE    = 3;
  localparam int unsigned CB_CMASK = 5;
  // status bit positions
  localparam int unsigned SB_RDY   = 0;
  localparam int unsigned SB_CLIVE = 1;
  localparam int unsigned SB_SLIVE = 2;
  localparam int unsigned SB_CSTK  = 5;
  localparam int unsigned SB_SSTK  = 6;

  typedef struct packed {
    logic cmask;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rng_noise_lfsr.sv
module rng_noise_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] word
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = st_q[0] ? ((st_q >> 1) ^ TAPS) : (st_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign word = st_q;
endmodule

// File: rtl/rng_condition_pipe.sv
module rng_condition_pipe #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         adv,
  input  logic [W-1:0] in_word,
  output logic         out_vld,
  output logic [W-1:0] out_word
);
  logic [W-1:0] dat_q [STAGES];
  logic         vld_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int unsigned ROT = ((7 * (i + 1)) % (W - 1)) + 1;
    logic [W-1:0] src, mixed, dat_d;
    logic         src_v, vld_d;

    if (i == 0) begin : g_head
      assign src   = in_word;
      assign src_v = 1'b1;
    end else begin : g_body
      assign src   = dat_q[i-1];
      assign src_v = vld_q[i-1];
    end

    assign mixed = src ^ {src[W-1-ROT:0], src[W-1:W-ROT]};

    always_comb begin
      dat_d = dat_q[i];
      vld_d = vld_q[i];
      if (flush) begin
        vld_d = 1'b0;
      end else if (adv) begin
        dat_d = mixed;
        vld_d = src_v;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[i] <= '0;
        vld_q[i] <= 1'b0;
      end else begin
        dat_q[i] <= dat_d;
        vld_q[i] <= vld_d;
      end
    end
  end

  assign out_vld  = vld_q[STAGES-1];
  assign out_word = dat_q[STAGES-1];
endmodule

// File: rtl/rng_word_fifo.sv
module rng_word_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_pop  = pop && (cnt_q != '0) && !flush;
  assign do_push = push && !flush;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/rng_regif.sv
module rng_regif
  import rng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned PIPE_STAGES = 2,
  parameter int unsigned DRAIN_READS = 12,
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned DRAIN_W    = $clog2(DRAIN_READS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              fault_inject,
  input  logic              clk_fault,
  output logic              irq
);
  ctrl_t              ctrl_q, ctrl_d;
  logic               slive_q, slive_d, sstk_q, sstk_d;
  logic               clive_q, clive_d, cstk_q, cstk_d;
  logic [DRAIN_W-1:0] drain_q, drain_d;

  logic wr_ctrl, wr_stat, rd_data, rd_any;
  logic seed_hit, clk_hit, halted, draining, drdy;
  logic running, drain_step, flush, accept, pipe_adv, push, pop;
  logic [WORD_W-1:0] noise, pipe_word, fifo_head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              pipe_vld;

  // decode
  assign rd_any  = bus_sel && !bus_wr;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign rd_data = rd_any && (bus_addr == ADDR_W'(OFF_DATA));

  // conditions
  assign seed_hit   = ctrl_q.en && fault_inject;
  assign clk_hit    = ctrl_q.en && !ctrl_q.cmask && clk_fault;
  assign halted     = slive_q || sstk_q;
  assign draining   = (drain_q != '0);
  assign drdy       = ctrl_q.en && !halted && !draining && (fifo_cnt == CNT_W'(FIFO_DEPTH));
  assign drain_step = rd_data && draining && !halted;
  assign pop        = rd_data && drdy;
  assign running    = ctrl_q.en && !halted && !draining && !seed_hit;
  assign flush      = !ctrl_d.en || seed_hit || halted;
  assign accept     = (fifo_cnt < CNT_W'(FIFO_DEPTH)) || pop;
  assign pipe_adv   = running && accept;
  assign push       = pipe_adv && pipe_vld;

  // next state
  always_comb begin
    ctrl_d  = ctrl_q;
    slive_d = seed_hit;
    clive_d = clk_hit;
    sstk_d  = sstk_q;
    cstk_d  = cstk_q;
    drain_d = drain_q;

    if (wr_ctrl) begin
      ctrl_d.en    = bus_wdata[CB_EN];
      ctrl_d.ie    = bus_wdata[CB_IE];
      ctrl_d.cmask = bus_wdata[CB_CMASK];
    end

    if (wr_stat && !bus_wdata[SB_SSTK]) sstk_d = 1'b0;
    if (wr_stat && !bus_wdata[SB_CSTK]) cstk_d = 1'b0;
    if (seed_hit) sstk_d = 1'b1;
    if (clk_hit)  cstk_d = 1'b1;

    if (sstk_q && !sstk_d)
      drain_d = DRAIN_W'(DRAIN_READS);
    else if (drain_step)
      drain_d = drain_q - 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      slive_q <= 1'b0;
      sstk_q  <= 1'b0;
      clive_q <= 1'b0;
      cstk_q  <= 1'b0;
      drain_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      slive_q <= slive_d;
      sstk_q  <= sstk_d;
      clive_q <= clive_d;
      cstk_q  <= cstk_d;
      drain_q <= drain_d;
    end
  end

  rng_noise_lfsr #(.W(WORD_W)) u_noise (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pipe_adv),
    .word  (noise)
  );

  rng_condition_pipe #(.W(WORD_W), .STAGES(PIPE_STAGES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .adv      (pipe_adv),
    .in_word  (noise),
    .out_vld  (pipe_vld),
    .out_word (pipe_word)
  );

  rng_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (pipe_word),
    .head  (fifo_head),
    .count (fifo_cnt)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (bus_addr)
        ADDR_W'(OFF_CTRL): begin
          bus_rdata[CB_EN]    = ctrl_q.en;
          bus_rdata[CB_IE]    = ctrl_q.ie;
          bus_rdata[CB_CMASK] = ctrl_q.cmask;
        end
        ADDR_W'(OFF_STAT): begin
          bus_rdata[SB_RDY]   = drdy;
          bus_rdata[SB_CLIVE] = clive_q;
          bus_rdata[SB_SLIVE] = slive_q;
          bus_rdata[SB_CSTK]  = cstk_q;
          bus_rdata[SB_SSTK]  = sstk_q;
        end
        ADDR_W'(OFF_DATA): begin
          if (drdy)            bus_rdata = fifo_head;
          else if (drain_step) bus_rdata = pipe_word;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = ctrl_q.ie && (drdy || sstk_q || cstk_q);
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned CNT_W      = 3,
  parameter int unsigned DRAIN_W    = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               drdy,
  input logic               slive,
  input logic               sstk,
  input logic               cstk,
  input logic [DRAIN_W-1:0] drain,
  input logic [CNT_W-1:0]   fifo_cnt,
  input logic               dr_read,
  input logic               st_write,
  input logic               ie,
  input logic               irq
);
  assert_halt_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slive || sstk) |-> !drdy);

  assert_drain_no_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drain != '0) |-> !drdy);

  assert_drain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((drain != '0) && dr_read && !slive && !sstk && !st_write)
      |=> (drain == DRAIN_W'($past(drain) - 1'b1)));

  assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drdy |-> (fifo_cnt == CNT_W'(FIFO_DEPTH)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sstk && !st_write) |=> sstk);

  assert_irq_seed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && sstk) |-> irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie) |-> !irq);

  assert_irq_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && cstk) |-> irq);
endmodule

bind rng_regif rng_regif_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .CNT_W      (CNT_W),
  .DRAIN_W    (DRAIN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .drdy     (drdy),
  .slive    (slive_q),
  .sstk     (sstk_q),
  .cstk     (cstk_q),
  .drain    (drain_q),
  .fifo_cnt (fifo_cnt),
  .dr_read  (rd_data),
  .st_write (wr_stat),
  .ie       (ctrl_q.ie),
  .irq      (irq)
);

// File: tb/tb_rng_regif.sv
`timescale 1ns/1ps
module tb_rng_regif;
  logic        clk, rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fault_inject, clk_fault, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;

  rng_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fault_inject(fault_inject), .clk_fault(clk_fault), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // one-cycle read; consecutive calls give back-to-back accesses
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    bus_sel = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input int lim, output bit got);
    logic [31:0] s;
    got = 0;
    for (int i = 0; i < lim; i++) begin
      rd(A_STAT, s);
      if (s[0]) begin got = 1; break; end
    end
    idle(0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_STAT, v); check("R1 stat", v, 32'h0);
    rd(A_DATA, v); check("R1 data", v, 32'h0);
    idle(0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFD3);           // every bit except 2,3,5
    rd(A_CTRL, v); check("R2 ignored bits", v, 32'h0);
    wr(A_CTRL, 32'h0000_0028);
    rd(A_CTRL, v); check("R2 ie+mask", v, 32'h28);
    rd(A_DATA, v); check("R3 read with ready low", v, 32'h0);
    wr(A_CTRL, 32'h0);
    idle(0);
  endtask

  task automatic t_burst();
    bit got;
    logic [31:0] w[4];
    logic [31:0] s;
    wr(A_CTRL, 32'h4);
    wait_ready(30, got);
    check("R3 ready after enable", {31'b0, got}, 32'h1);
    for (int i = 0; i < 4; i++) rd(A_DATA, w[i]);
    idle(0);
    for (int i = 1; i < 4; i++)
      check("R3 distinct words", {31'b0, (w[i] != w[i-1])}, 32'h1);
    rd(A_STAT, s); idle(0);
    check("R3 ready after refill", s & 32'h1, 32'h1);
  endtask

  task automatic t_seed();
    logic [31:0] v;
    bit got;
    @(negedge clk); fault_inject = 1'b1;
    idle(2);
    rd(A_STAT, v); check("R4 fault status", v, 32'h44);
    rd(A_DATA, v); check("R4 data blocked", v, 32'h0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R10 clear while faulty", v, 32'h44);
    idle(0);
    fault_inject = 1'b0;
    idle(2);
    rd(A_STAT, v); check("R5 live bit follows", v, 32'h40);
    wr(A_STAT, 32'h40);
    rd(A_STAT, v); check("R5 write one keeps", v, 32'h40);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R5 write zero clears", v, 32'h0);
    for (int i = 0; i < 11; i++) rd(A_DATA, v);
    idle(40);
    rd(A_STAT, v); check("R6 ready held before 12th read", v & 32'h1, 32'h0);
    rd(A_DATA, v);
    idle(0);
    wait_ready(30, got);
    check("R6 ready after drain", {31'b0, got}, 32'h1);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    bit got;
    wr(A_CTRL, 32'h0);
    rd(A_STAT, v); check("R7 ready drops", v & 32'h1, 32'h0);
    rd(A_DATA, v); check("R7 data zero", v, 32'h0);
    idle(0);
    wr(A_CTRL, 32'h4);
    rd(A_STAT, v); check("R7 refill from empty", v & 32'h1, 32'h0);
    idle(0);
    wait_ready(30, got);
    check("R7 ready again", {31'b0, got}, 32'h1);
  endtask

  task automatic t_clock();
    logic [31:0] v;
    @(negedge clk); clk_fault = 1'b1;
    idle(2);
    rd(A_STAT, v); check("R8 clock error flags", v, 32'h23);
    idle(0);
    clk_fault = 1'b0;
    idle(2);
    rd(A_STAT, v); check("R8 sticky remains", v, 32'h21);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 sticky cleared", v, 32'h01);
    wr(A_CTRL, 32'h24);
    idle(0);
    clk_fault = 1'b1;
    idle(3);
    rd(A_STAT, v); check("R8 masked", v & 32'h22, 32'h0);
    idle(0);
    clk_fault = 1'b0;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_CTRL, 32'h0C);
    idle(1);
    rd(A_STAT, v); idle(0);
    check("R9 ready visible", v & 32'h1, 32'h1);
    check("R9 irq on ready", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h04);
    idle(1);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    fault_inject = 1'b0; clk_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_burst();
    t_seed();
    t_disable();
    t_clock();
    t_irq();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule